// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address for each beat of a four-beat memory burst. A full base address is captured when either of two address strobes is high on a rising clock edge. After that, the two least significant address bits are stepped internally, one step for each edge on which the advance input is high. The upper address bits are taken from the base address and never change during the burst.

Two beat orderings are offered. The linear ordering adds the beat count to the starting offset and wraps modulo four. The interleaved ordering combines the starting offset and the beat count with XOR. The ordering is chosen by a mode input that is captured together with the base address. The block outputs the current full address and the current beat index. It holds no memory array and handles no data. All of its pins are plain control and address signals, so it has no valid/ready handshake and no back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and after its release, `beat_idx` is 0 and `burst_addr` is all zeros until the first strobe.
- R2: On a rising edge where `strobe_cpu` or `strobe_ctl` is high, `base_addr` and `seq_mode` are captured. From the next cycle `burst_addr` equals the captured base and `beat_idx` is 0.
- R3: A strobe during a burst reloads the base and clears the beat count. When a strobe and `advance` are high on the same edge, the strobe wins.
- R4: On an edge with no strobe and `advance` high, `beat_idx` increases by 1 modulo 4.
- R5: On an edge with no strobe and `advance` low, `beat_idx` and `burst_addr` keep their values (wait state).
- R6: With captured `seq_mode` = 0 (linear), the low two address bits equal (start + beat_idx) mod 4.
- R7: With captured `seq_mode` = 1 (interleaved), the low two address bits equal start XOR beat_idx. For example, start 01 gives 01, 00, 11, 10.
- R8: Bits above bit 1 of `burst_addr` keep the captured base value through every beat, including the wrap after beat 3. The count never carries into them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_cpu | input | 1 | Processor-side address strobe, loads base |
| strobe_ctl | input | 1 | Controller-side address strobe, loads base |
| base_addr | input | AW | Starting address of the burst |
| seq_mode | input | 1 | Beat ordering: 0 linear, 1 interleaved |
| advance | input | 1 | Step to the next beat on this edge |
| burst_addr | output | AW | Address of the current beat |
| beat_idx | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Both orderings are run with starting offsets 01 and 11. These offsets separate addition from XOR, and they force a modulo-four wrap part way through the burst. One base has every upper bit set, so any carry out of the low bits into the upper bits would show. Gaps in `advance` are placed between beats to show that a wait state holds both outputs. A reload with `advance` held high shows that the strobe takes priority. Each strobe line is also used on its own.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;
  typedef enum logic {SEQ_LINEAR = 1'b0, SEQ_XOR = 1'b1} seq_mode_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  step,
  output beat_t count
);
  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= '0;
    else if (step) count <= count + beat_t'(1);
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic          mode_in,
  output logic [AW-1:0] base_q,
  output seq_mode_e     mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= SEQ_LINEAR;
    end else if (load) begin
      base_q <= base_in;
      mode_q <= seq_mode_e'(mode_in);
    end
  end
endmodule

// File: rtl/burst_low_map.sv
module burst_low_map
  import burst_pkg::*;
(
  input  beat_t     start,
  input  beat_t     count,
  input  seq_mode_e mode,
  output beat_t     low
);
  beat_t lin_low;
  beat_t xor_low;
  assign lin_low = start + count;
  assign xor_low = start ^ count;
  always_comb begin
    case (mode)
      SEQ_XOR: low = xor_low;
      default: low = lin_low;
    endcase
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_cpu,
  input  logic          strobe_ctl,
  input  logic [AW-1:0] base_addr,
  input  logic          seq_mode,
  input  logic          advance,
  output logic [AW-1:0] burst_addr,
  output logic [1:0]    beat_idx
);
  localparam int UW = AW - BEAT_W;

  logic          load;
  logic [AW-1:0] base_q;
  seq_mode_e     mode_q;
  beat_t         count;
  beat_t         low;

  assign load = strobe_cpu | strobe_ctl;

  burst_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .load(load),
    .base_in(base_addr), .mode_in(seq_mode),
    .base_q(base_q), .mode_q(mode_q)
  );

  burst_beat_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(load),
    .step(advance), .count(count)
  );

  burst_low_map u_map (
    .start(base_q[BEAT_W-1:0]), .count(count),
    .mode(mode_q), .low(low)
  );

  assign burst_addr = {base_q[AW-1:BEAT_W], low};
  assign beat_idx   = count;

  initial begin
    if (UW < 1) $error("AW must exceed the beat width");
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          strobe_cpu,
  input logic          strobe_ctl,
  input logic [AW-1:0] base_addr,
  input logic          advance,
  input logic [AW-1:0] burst_addr,
  input logic [1:0]    beat_idx
);
  // R2
  load_takes_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_cpu || strobe_ctl) |=> (beat_idx == 2'd0) && (burst_addr == $past(base_addr)));

  // R3
  strobe_beats_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((strobe_cpu || strobe_ctl) && advance) |=> beat_idx == 2'd0);

  // R4
  step_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && advance) |=> beat_idx == 2'($past(beat_idx) + 2'd1));

  // R5
  wait_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl && !advance) |=> $stable(burst_addr) && $stable(beat_idx));

  // R8
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_cpu && !strobe_ctl) |=> $stable(burst_addr[AW-1:2]));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
  .base_addr(base_addr), .advance(advance),
  .burst_addr(burst_addr), .beat_idx(beat_idx)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] addr;
    logic [1:0]    beat;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe_cpu = 1'b0;
  logic          strobe_ctl = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          seq_mode = 1'b0;
  logic          advance = 1'b0;
  logic [AW-1:0] burst_addr;
  logic [1:0]    beat_idx;

  int checks = 0;
  int fails = 0;
  exp_t sb[$];

  logic [AW-1:0] m_base = '0;
  logic          m_mode = 1'b0;
  logic [1:0]    m_cnt = '0;

  always #5 clk = ~clk;

  burst_addr_gen #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .base_addr(base_addr), .seq_mode(seq_mode), .advance(advance),
    .burst_addr(burst_addr), .beat_idx(beat_idx)
  );

  function automatic logic [AW-1:0] model_addr();
    logic [1:0] s;
    logic [1:0] lo;
    s  = m_base[1:0];
    lo = m_mode ? (s ^ m_cnt) : 2'(s + m_cnt);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic compare(input logic [AW-1:0] ea, input logic [1:0] eb, input string tag);
    checks++;
    if (burst_addr !== ea || beat_idx !== eb) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, burst_addr, beat_idx, ea, eb);
    end
  endtask

  task automatic drive(input logic sa, input logic sc, input logic [AW-1:0] b,
                       input logic m, input logic adv, input string tag);
    exp_t e;
    @(negedge clk);
    strobe_cpu = sa; strobe_ctl = sc; base_addr = b; seq_mode = m; advance = adv;
    if (sa || sc) begin
      m_base = b; m_mode = m; m_cnt = 2'd0;
    end else if (adv) begin
      m_cnt = m_cnt + 2'd1;
    end
    e.addr = model_addr(); e.beat = m_cnt; e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        compare(e.addr, e.beat, e.tag);
      end
    end
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 compare('0, 2'd0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2 compare('0, 2'd0, "R1 after reset");

    // linear, start 01, processor strobe
    drive(1, 0, 20'h12345, 0, 0, "R2 load cpu strobe");
    drive(0, 0, 20'h0, 0, 1, "R6 linear beat1");
    drive(0, 0, 20'h0, 0, 0, "R5 wait state");
    drive(0, 0, 20'h0, 0, 0, "R5 wait state 2");
    drive(0, 0, 20'h0, 0, 1, "R6 linear beat2");
    drive(0, 0, 20'h0, 0, 1, "R6 linear beat3 wrap low");
    drive(0, 0, 20'h0, 0, 1, "R4 beat wraps to 0");

    // interleaved, start 01, controller strobe: 01,00,11,10
    drive(0, 1, 20'hABCD1, 1, 0, "R2 load ctl strobe");
    drive(0, 0, 20'h0, 0, 1, "R7 xor beat1");
    drive(0, 0, 20'h0, 0, 1, "R7 xor beat2");
    drive(0, 0, 20'h0, 0, 0, "R5 wait xor");
    drive(0, 0, 20'h0, 0, 1, "R7 xor beat3");

    // mid-burst reload with advance high
    drive(0, 0, 20'h0, 0, 1, "R4 step before reload");
    drive(1, 0, 20'h00F02, 0, 1, "R3 reload beats advance");
    drive(0, 0, 20'h0, 1, 1, "R6 mode held from load");

    // upper bits all ones, linear start 11
    drive(0, 1, 20'hFFFFF, 0, 0, "R8 load top base");
    for (int i = 0; i < 5; i++) drive(0, 0, 20'h0, 0, 1, "R8 upper kept");

    // interleaved start 11 with both strobes
    drive(1, 1, 20'h5555F, 1, 0, "R2 both strobes");
    for (int i = 0; i < 4; i++) drive(0, 0, 20'h0, 0, 1, "R7 xor start 11");

    drive(0, 0, 20'h0, 0, 0, "R5 final hold");
    repeat (3) @(posedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule